// File: doc/BRIEF.md
# Dual-Channel DAC Serial Frame Driver

This block sits on the host side of a link to a dual-channel, 12-bit, voltage-output converter that is loaded over a three-pin serial port. A client hands it two channel codes with a valid/ready handshake. The block packs both codes into one 24-bit frame and clocks the frame out on a serial clock pin and a data pin, framed by a select/load pin. The select/load pin is held low for the whole frame. Its rising edge tells the receiver to move the shifted word into its output registers.

The receiver has minimum timing intervals that must be met. These are the clock high and low widths, how long the clock must sit low before select falls, the gap from select falling to the first clock edge, the gap from the last clock edge to select rising, and the time select must stay high between frames. Each interval is given in nanoseconds as a parameter and turned into a count of system clock cycles at elaboration, rounding up.

When idle, the clock pin is low and select/load is high. The block raises a one-cycle done pulse once select/load has been high for its minimum time, and in that same cycle it is ready for the next pair of codes.

Top module: `dual_code_serializer`

## Requirements
- R1: After reset and whenever no frame is in progress, `ser_frame_n` is 1, `ser_clk` is 0 and `done` is 0.
- R2: Each frame carries 24 bits, sampled on the rising edges of `ser_clk`. The order is `code_a` bit 11 down to bit 0, then `code_b` bit 11 down to bit 0.
- R3: `ser_data` never changes in a cycle where `ser_clk` is 1. Each bit is therefore stable across the rising edge that samples it.
- R4: Every high phase of `ser_clk` lasts at least ceil(CLK_HIGH_NS/CLK_PERIOD_NS) cycles. Every low phase between two rising edges of a frame lasts at least ceil(CLK_LOW_NS/CLK_PERIOD_NS) cycles.
- R5: `ser_clk` is never 1 while `ser_frame_n` is 1. `ser_clk` has been 0 for at least ceil(CLK_LOW_TO_SEL_NS/CLK_PERIOD_NS) cycles when `ser_frame_n` falls.
- R6: The first rising edge of `ser_clk` comes at least ceil(SEL_TO_CLK_NS/CLK_PERIOD_NS) cycles after `ser_frame_n` falls.
- R7: `ser_frame_n` rises at least ceil(LAST_CLK_TO_LOAD_NS/CLK_PERIOD_NS) cycles after the last rising edge of `ser_clk`.
- R8: Between frames, `ser_frame_n` stays 1 for at least ceil(LOAD_HIGH_NS/CLK_PERIOD_NS) cycles. `done` is a single-cycle pulse, raised once per frame after that high time has elapsed.
- R9: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `ser_frame_n` falls in the next cycle. `req_ready` is 0 from acceptance until the `done` cycle, which it shares. While `req_ready` is 0, `req_valid` and the codes have no effect.
- R10: Exactly 24 rising edges of `ser_clk` occur while `ser_frame_n` is low in one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a pair of codes |
| req_ready | output | 1 | Block is idle and will take a request this cycle |
| code_a | input | CODE_W | Channel A code, shifted first |
| code_b | input | CODE_W | Channel B code, shifted second |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_data | output | 1 | Serial data to the converter |
| ser_frame_n | output | 1 | Select/load: low during a frame, rising edge loads |
| done | output | 1 | One-cycle pulse when a frame is complete |

## Verification
The bench aims at the frame edges. The first and last bits are checked with codes that are all zeros, all ones, complementary between channels, or a single set bit at each end. A design that swapped the channels, sent LSB first, or dropped or added one shift would fail the decoded-word comparison or the edge count. Interval checks are made at every select and clock transition. A design that raised the clock together with select falling, loaded before the last high phase ended, or restarted too soon after load would show a short interval. Requests offered while busy, and codes changed mid-frame, must leave the frame in flight untouched and must not start another. Back-to-back requests check that the next frame starts in the first idle cycle with the inter-frame gap kept.

// File: rtl/dacser_pkg.sv
`timescale 1ns/1ps
package dacser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } dser_state_e;

    typedef struct packed {
        logic clk_lvl;
        logic frame_lvl;
    } dser_pins_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return max2(c, 1);
    endfunction

endpackage

// File: rtl/dacser_timer.sv
`timescale 1ns/1ps
module dacser_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dacser_shifter.sv
`timescale 1ns/1ps
module dacser_shifter #(
    parameter int FRAME_W = 24,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               advance,
    output logic               bit_out,
    output logic               last_bit
);
    logic [FRAME_W-1:0] sreg_q;
    logic [IDX_W-1:0]   idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            sreg_q <= frame_in;
            idx_q  <= IDX_W'(FRAME_W - 1);
        end else if (advance) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
            idx_q  <= idx_q - 1'b1;
        end
    end

    assign bit_out  = sreg_q[FRAME_W-1];
    assign last_bit = (idx_q == '0);

    AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (rst)
        advance |-> (idx_q != '0)); // R10

endmodule

// File: rtl/dual_code_serializer.sv
`timescale 1ns/1ps
module dual_code_serializer #(
    parameter int CODE_W              = 12,
    parameter int CLK_PERIOD_NS       = 20,
    parameter int CLK_HIGH_NS         = 60,
    parameter int CLK_LOW_NS          = 60,
    parameter int CLK_LOW_TO_SEL_NS   = 30,
    parameter int SEL_TO_CLK_NS       = 30,
    parameter int LAST_CLK_TO_LOAD_NS = 60,
    parameter int LOAD_HIGH_NS        = 80,
    parameter int CNT_W               = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_frame_n,
    output logic              done
);
    import dacser_pkg::*;

    localparam int FRAME_W = 2 * CODE_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    localparam int unsigned HI_CYC        = ns_to_cycles(CLK_HIGH_NS, CLK_PERIOD_NS);
    localparam int unsigned LO_CYC        = ns_to_cycles(CLK_LOW_NS, CLK_PERIOD_NS);
    localparam int unsigned CLK_SEL_CYC   = ns_to_cycles(CLK_LOW_TO_SEL_NS, CLK_PERIOD_NS);
    localparam int unsigned SEL_CLK_CYC   = ns_to_cycles(SEL_TO_CLK_NS, CLK_PERIOD_NS);
    localparam int unsigned LAST_LOAD_CYC = ns_to_cycles(LAST_CLK_TO_LOAD_NS, CLK_PERIOD_NS);
    localparam int unsigned LOAD_HI_CYC   = ns_to_cycles(LOAD_HIGH_NS, CLK_PERIOD_NS);

    // First low phase must satisfy both the select setup and the low width.
    localparam int unsigned FIRST_LO_CYC  = max2(SEL_CLK_CYC, LO_CYC);
    // The high phase already counts toward the last-edge-to-load interval.
    localparam int unsigned TAIL_CYC      = (LAST_LOAD_CYC > HI_CYC) ? (LAST_LOAD_CYC - HI_CYC) : 1;
    // Select high time also covers the clock-low-before-select interval.
    localparam int unsigned GAP_CYC       = max2(LOAD_HI_CYC, CLK_SEL_CYC);

    localparam logic [CNT_W-1:0] LD_HI    = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LD_LO    = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] LD_FIRST = CNT_W'(FIRST_LO_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TAIL  = CNT_W'(TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_CYC - 1);

    dser_state_e      st_q, st_n;
    dser_pins_t       pins_q, pins_n;
    logic             done_q, done_n;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sh_load, sh_adv, sh_bit, sh_last;

    dacser_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dacser_shifter #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .frame_in ({code_a, code_b}),
        .advance  (sh_adv),
        .bit_out  (sh_bit),
        .last_bit (sh_last)
    );

    always_comb begin
        st_n     = st_q;
        pins_n   = pins_q;
        done_n   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    sh_load          = 1'b1;
                    tmr_load         = 1'b1;
                    tmr_val          = LD_FIRST;
                    pins_n.frame_lvl = 1'b0;
                    st_n             = ST_SETUP;
                end
            end
            ST_SETUP, ST_LOW: begin
                if (tmr_expired) begin
                    pins_n.clk_lvl = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = LD_HI;
                    st_n           = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    pins_n.clk_lvl = 1'b0;
                    tmr_load       = 1'b1;
                    if (sh_last) begin
                        tmr_val = LD_TAIL;
                        st_n    = ST_TAIL;
                    end else begin
                        sh_adv  = 1'b1;
                        tmr_val = LD_LO;
                        st_n    = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_expired) begin
                    pins_n.frame_lvl = 1'b1;
                    tmr_load         = 1'b1;
                    tmr_val          = LD_GAP;
                    st_n             = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    done_n = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q             <= ST_IDLE;
            pins_q.clk_lvl   <= 1'b0;
            pins_q.frame_lvl <= 1'b1;
            done_q           <= 1'b0;
        end else begin
            st_q   <= st_n;
            pins_q <= pins_n;
            done_q <= done_n;
        end
    end

    assign req_ready   = (st_q == ST_IDLE);
    assign ser_clk     = pins_q.clk_lvl;
    assign ser_frame_n = pins_q.frame_lvl;
    assign ser_data    = sh_bit;
    assign done        = done_q;

    // Interval counters feeding the assertions below.
    localparam logic [CNT_W-1:0] SAT = '1;
    logic [CNT_W-1:0] chk_hi_run, chk_lo_run, chk_sel_hi_run, chk_sel_lo_run, chk_since_rise;
    logic [IDX_W:0]   chk_rise_cnt;
    logic             chk_clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_hi_run     <= '0;
            chk_lo_run     <= SAT;
            chk_sel_hi_run <= SAT;
            chk_sel_lo_run <= '0;
            chk_since_rise <= SAT;
            chk_rise_cnt   <= '0;
            chk_clk_d      <= 1'b0;
        end else begin
            chk_clk_d      <= ser_clk;
            chk_hi_run     <= ser_clk ? ((chk_hi_run == SAT) ? SAT : chk_hi_run + 1'b1) : '0;
            chk_lo_run     <= ser_clk ? '0 : ((chk_lo_run == SAT) ? SAT : chk_lo_run + 1'b1);
            chk_sel_hi_run <= ser_frame_n ? ((chk_sel_hi_run == SAT) ? SAT : chk_sel_hi_run + 1'b1) : '0;
            chk_sel_lo_run <= ser_frame_n ? '0 : ((chk_sel_lo_run == SAT) ? SAT : chk_sel_lo_run + 1'b1);
            if (ser_clk && !chk_clk_d)
                chk_since_rise <= CNT_W'(1);
            else if (chk_since_rise != SAT)
                chk_since_rise <= chk_since_rise + 1'b1;
            if (ser_frame_n)
                chk_rise_cnt <= '0;
            else if (ser_clk && !chk_clk_d)
                chk_rise_cnt <= chk_rise_cnt + 1'b1;
        end
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (ser_frame_n && !ser_clk)); // R1

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data)); // R3

    AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> (chk_hi_run >= CNT_W'(HI_CYC))); // R4

    AST_CLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(ser_clk) && (chk_rise_cnt != '0)) |-> (chk_lo_run >= CNT_W'(LO_CYC))); // R4

    AST_NO_CLK_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        ser_frame_n |-> !ser_clk); // R5

    AST_CLK_LOW_BEFORE_SEL: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_frame_n) |-> (chk_lo_run >= CNT_W'(CLK_SEL_CYC))); // R5

    AST_SEL_TO_FIRST_EDGE: assert property (@(posedge clk) disable iff (rst)
        ($rose(ser_clk) && (chk_rise_cnt == '0)) |-> (chk_sel_lo_run >= CNT_W'(SEL_CLK_CYC))); // R6

    AST_LAST_EDGE_TO_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_frame_n) |-> (chk_since_rise >= CNT_W'(LAST_LOAD_CYC))); // R7

    AST_LOAD_HIGH_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (ser_frame_n && (chk_sel_hi_run >= CNT_W'(LOAD_HI_CYC)))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !ser_frame_n); // R9

    AST_SELECT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_frame_n) |-> $past(req_valid && req_ready)); // R9

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_frame_n) |-> (chk_rise_cnt == (IDX_W+1)'(FRAME_W))); // R10

endmodule

// File: tb/dual_code_serializer_bench.sv
`timescale 1ns/1ps
module dual_code_serializer_bench;

    localparam int PERIOD  = 20;
    localparam int FRAME_W = 24;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PERIOD - 1) / PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int HI_MIN     = cyc(60);
    localparam int LO_MIN     = cyc(60);
    localparam int CLKSEL_MIN = cyc(30);
    localparam int SELCLK_MIN = cyc(30);
    localparam int LAST_MIN   = cyc(60);
    localparam int LOADHI_MIN = cyc(80);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] code_a = '0;
    logic [11:0] code_b = '0;
    logic        ser_clk, ser_data, ser_frame_n, done;

    always #10 clk = ~clk;

    dual_code_serializer u_dual_code_serializer (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .code_a      (code_a),
        .code_b      (code_b),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_frame_n (ser_frame_n),
        .done        (done)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Pin monitor, sampled on the falling edge.
    int          hi_cnt, lo_cnt, sel_hi_cnt, sel_lo_cnt, since_rise, rises;
    int          frames = 0;
    int          done_cnt = 0;
    logic [23:0] shreg, exp_frame;
    logic        p_clk, p_sel, p_data, p_done;

    always @(negedge clk) begin
        if (rst) begin
            hi_cnt = 0; lo_cnt = 1000; sel_hi_cnt = 1000; sel_lo_cnt = 0;
            since_rise = 1000; rises = 0; shreg = '0;
            p_clk = ser_clk; p_sel = ser_frame_n; p_data = ser_data; p_done = done;
        end else begin
            automatic bit rise  = ser_clk && !p_clk;
            automatic bit fall  = !ser_clk && p_clk;
            automatic bit sfall = !ser_frame_n && p_sel;
            automatic bit srise = ser_frame_n && !p_sel;
            if (ser_frame_n && ser_clk)
                check(1'b0, "R5", "clock high while deselected", 1, 0);
            if (ser_clk && (ser_data != p_data))
                check(1'b0, "R3", "data changed while clock high", ser_data, p_data);
            if (!ser_frame_n && req_ready)
                check(1'b0, "R9", "ready high during frame", 1, 0);
            if (rise) begin
                if (rises == 0)
                    check(sel_lo_cnt >= SELCLK_MIN, "R6", "select-to-first-edge cycles", sel_lo_cnt, SELCLK_MIN);
                else
                    check(lo_cnt >= LO_MIN, "R4", "clock low cycles", lo_cnt, LO_MIN);
                rises++;
                shreg = {shreg[22:0], ser_data};
            end
            if (fall)
                check(hi_cnt >= HI_MIN, "R4", "clock high cycles", hi_cnt, HI_MIN);
            if (sfall) begin
                check(lo_cnt >= CLKSEL_MIN, "R5", "clock low before select", lo_cnt, CLKSEL_MIN);
                check(sel_hi_cnt >= LOADHI_MIN, "R8", "select high between frames", sel_hi_cnt, LOADHI_MIN);
                rises = 0;
            end
            if (srise) begin
                check(rises == FRAME_W, "R10", "rising edges per frame", rises, FRAME_W);
                check(shreg == exp_frame, "R2", "decoded frame", shreg, exp_frame);
                check(since_rise >= LAST_MIN, "R7", "last edge to load cycles", since_rise, LAST_MIN);
                frames++;
            end
            if (done) begin
                check(ser_frame_n && (sel_hi_cnt >= LOADHI_MIN), "R8", "select high cycles at done", sel_hi_cnt, LOADHI_MIN);
                check(req_ready == 1'b1, "R9", "ready in done cycle", req_ready, 1);
                if (p_done) check(1'b0, "R8", "done longer than one cycle", 2, 1);
                done_cnt++;
            end
            hi_cnt     = ser_clk ? hi_cnt + 1 : 0;
            lo_cnt     = ser_clk ? 0 : lo_cnt + 1;
            sel_hi_cnt = ser_frame_n ? sel_hi_cnt + 1 : 0;
            sel_lo_cnt = ser_frame_n ? 0 : sel_lo_cnt + 1;
            since_rise = rise ? 1 : since_rise + 1;
            p_clk = ser_clk; p_sel = ser_frame_n; p_data = ser_data; p_done = done;
        end
    end

    task automatic issue(input logic [11:0] a, input logic [11:0] b);
        @(negedge clk);
        code_a    = a;
        code_b    = b;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        exp_frame = {a, b};
        @(negedge clk);
        req_valid = 1'b0;
        check(ser_frame_n == 1'b0, "R9", "select low after acceptance", ser_frame_n, 0);
    endtask

    task automatic wait_done(input int target);
        int guard = 0;
        while (done_cnt < target && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(ser_frame_n == 1'b1, "R1", "idle select level", ser_frame_n, 1);
        check(ser_clk == 1'b0, "R1", "idle clock level", ser_clk, 0);
        check(done == 1'b0, "R1", "idle done", done, 0);
        check(req_ready == 1'b1, "R1", "idle ready", req_ready, 1);
    endtask

    task automatic t_frame(input logic [11:0] a, input logic [11:0] b);
        int f0 = frames;
        int d0 = done_cnt;
        issue(a, b);
        wait_done(d0 + 1);
        check(done_cnt == d0 + 1, "R8", "done pulses for frame", done_cnt - d0, 1);
        check(frames == f0 + 1, "R2", "frames sent", frames - f0, 1);
        @(negedge clk);
        check(ser_frame_n && !ser_clk, "R1", "idle levels after frame", {ser_frame_n, ser_clk}, 2);
    endtask

    task automatic t_busy_ignore();
        int f0 = frames;
        int d0 = done_cnt;
        issue(12'h3C7, 12'hE18);
        repeat (10) @(negedge clk);
        check(req_ready == 1'b0, "R9", "ready low mid-frame", req_ready, 0);
        code_a = 12'h111; code_b = 12'h222; req_valid = 1'b1;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        code_a = 12'hFFF; code_b = 12'h000;
        wait_done(d0 + 1);
        repeat (40) @(negedge clk);
        check(frames == f0 + 1, "R9", "frames after busy request", frames - f0, 1);
        check(ser_frame_n == 1'b1, "R9", "no new frame after busy request", ser_frame_n, 1);
    endtask

    task automatic t_back_to_back();
        int f0 = frames;
        int d0 = done_cnt;
        int wait_cyc = 0;
        issue(12'h123, 12'h456);
        @(negedge clk);
        code_a = 12'hFED; code_b = 12'hCBA; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        check(done == 1'b1, "R9", "ready first seen with done", done, 1);
        exp_frame = {12'hFED, 12'hCBA};
        @(negedge clk);
        req_valid = 1'b0;
        check(ser_frame_n == 1'b0, "R9", "second frame starts at once", ser_frame_n, 0);
        wait_done(d0 + 2);
        check(frames == f0 + 2, "R2", "back-to-back frames", frames - f0, 2);
        while (!ser_frame_n && wait_cyc < 10) begin @(negedge clk); wait_cyc++; end
    endtask

    initial begin
        t_reset();
        t_frame(12'h000, 12'h000);
        t_frame(12'hFFF, 12'hFFF);
        t_frame(12'hFFF, 12'h000);
        t_frame(12'h000, 12'hFFF);
        t_frame(12'hA5A, 12'h5A5);
        t_frame(12'h800, 12'h001);
        t_frame(12'h001, 12'h800);
        t_busy_ignore();
        t_back_to_back();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule